// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

The block turns a small set of active-low external interrupt pins into pending flags for an interrupt controller. Each pin passes through its own synchroniser and can be set up to raise its flag from either the pin level or a falling edge. The choice is made by a trigger-mode bit that software holds in a shared control byte. The pending flags can also be read from that byte.

In level mode the flag simply shows the inverted synchronised pin, and nothing is stored. In edge mode a falling edge latches the flag. The flag stays set until the processor acknowledges the matching vector, or until software writes the bit. When an acknowledge and a new edge arrive in the same cycle, the flag stays set, so that edge is not lost.

Top module: `extint_cond`

## Requirements
- R1: After reset both trigger-mode bits are 0 (level) and, with the pins high, every pending output and every control-byte bit reads 0.
- R2: In level mode, a pin held low gives pending = 1 two clock edges after the pin changes (two-stage synchroniser).
- R3: In level mode nothing is latched: two edges after the pin returns high, pending is 0 again.
- R4: In edge mode, a high-to-low pin transition sets the pending flag three clock edges after the pin falls, and not earlier.
- R5: In edge mode, a set flag stays set while the pin goes back high, and a pin held low does not set the flag again once it has been cleared.
- R6: In edge mode, an acknowledge pulse on `vec_ack_i[k]` clears flag k at the next edge.
- R7: If a falling edge is detected in the same cycle as the acknowledge, the flag stays set.
- R8: In edge mode, a control write sets or clears the pending bit to the written value at the next edge. The write is taken when the mode before the write is edge, and it takes priority over an acknowledge in the same cycle.
- R9: In level mode, writes to a pending bit have no effect; pending still shows the pin.
- R10: Control byte layout: bit 2k is the trigger mode of pin k (1 = edge), bit 2k+1 is the pending flag of pin k. Bits above 2*NUM_PINS read 0. A write loads every mode bit at the next edge.
- R11: In level mode an acknowledge has no effect; pending still shows the pin.
- R12: The pins work independently: stimulus on one pin never changes the flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_ni | input | NUM_PINS | Asynchronous interrupt pins, active low |
| vec_ack_i | input | NUM_PINS | One-cycle acknowledge per pin when its vector is taken |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | REG_W | Control byte write data |
| ctrl_rdata_o | output | REG_W | Control byte read data |
| pend_o | output | NUM_PINS | Pending flags to the interrupt controller |

## Verification
A wrong synchroniser depth shows up as a pending output that moves one cycle early or late after a pin change. This is visible within three cycles. A broken edge latch shows up as a flag that drops when the pin rises, or is set again while the pin is held low, or is lost when an acknowledge coincides with a new edge. Each of these shows at `pend_o` and in the control byte one cycle after the event. A mode bit stored at the wrong place makes the read byte differ on the very next edge after a write.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  function automatic int unsigned mode_bit(input int unsigned k);
    return 2 * k;
  endfunction

  function automatic int unsigned pend_bit(input int unsigned k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // reset to the inactive (high) level so no edge is seen at reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_ni};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/extint_chan.sv
module extint_chan
  import extint_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic fall_i,
  input  logic ack_i,
  input  logic we_i,
  input  logic wmode_i,
  input  logic wpend_i,
  output logic mode_o,
  output logic pend_o
);
  trig_e mode_q, mode_d;
  logic  flag_q, flag_d;

  always_comb begin
    mode_d = we_i ? trig_e'(wmode_i) : mode_q;
    if (mode_q == TRIG_LEVEL) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
      if (ack_i)  flag_d = 1'b0;
      if (we_i)   flag_d = wpend_i;
      if (fall_i) flag_d = 1'b1;  // a new edge wins over ack and write
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TRIG_LEVEL;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o = (mode_q == TRIG_EDGE);
  assign pend_o = (mode_q == TRIG_EDGE) ? flag_q : ~lvl_i;
endmodule

// File: rtl/extint_cond.sv
module extint_cond
  import extint_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_W       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_ni,
  input  logic [NUM_PINS-1:0] vec_ack_i,
  input  logic                ctrl_we_i,
  input  logic [REG_W-1:0]    ctrl_wdata_i,
  output logic [REG_W-1:0]    ctrl_rdata_o,
  output logic [NUM_PINS-1:0] pend_o
);
  localparam int unsigned USED_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] sync_lvl;
  logic [NUM_PINS-1:0] sync_fall;
  logic [NUM_PINS-1:0] type_q;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (pin_ni[k]),
      .lvl_o  (sync_lvl[k]),
      .fall_o (sync_fall[k])
    );

    extint_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (sync_lvl[k]),
      .fall_i  (sync_fall[k]),
      .ack_i   (vec_ack_i[k]),
      .we_i    (ctrl_we_i),
      .wmode_i (ctrl_wdata_i[mode_bit(k)]),
      .wpend_i (ctrl_wdata_i[pend_bit(k)]),
      .mode_o  (type_q[k]),
      .pend_o  (pend_o[k])
    );

    assign ctrl_rdata_o[mode_bit(k)] = type_q[k];
    assign ctrl_rdata_o[pend_bit(k)] = pend_o[k];
  end

  if (REG_W > USED_W) begin : g_pad
    assign ctrl_rdata_o[REG_W-1:USED_W] = '0;
  end
endmodule

// File: rtl/extint_cond_chk.sv
module extint_cond_chk #(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned REG_W    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pin_ni,
  input logic [NUM_PINS-1:0] vec_ack_i,
  input logic                ctrl_we_i,
  input logic [REG_W-1:0]    ctrl_rdata_o,
  input logic [NUM_PINS-1:0] pend_o,
  input logic [NUM_PINS-1:0] sync_fall,
  input logic [NUM_PINS-1:0] type_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    // R2 / R3: level-mode pending equals pin inverted, two edges later
    a_r2_level_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2'd2 && !type_q[g]) |-> (pend_o[g] == !$past(pin_ni[g], 2)));

    a_r4_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_q[g] && sync_fall[g]) |=> (pend_o[g] || !type_q[g]));

    a_r5_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_q[g] && pend_o[g] && !vec_ack_i[g] && !ctrl_we_i) |=> pend_o[g]);

    a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_q[g] && vec_ack_i[g] && !ctrl_we_i && !sync_fall[g]) |=> !pend_o[g]);

    a_r7_edge_beats_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_q[g] && vec_ack_i[g] && sync_fall[g] && !ctrl_we_i) |=> pend_o[g]);
  end

  if (REG_W > 2 * NUM_PINS) begin : g_pad_chk
    a_r10_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ctrl_rdata_o[REG_W-1:2*NUM_PINS]) == 0);
  end
endmodule

bind extint_cond extint_cond_chk #(
  .NUM_PINS (NUM_PINS),
  .REG_W    (REG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pin_ni       (pin_ni),
  .vec_ack_i    (vec_ack_i),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .pend_o       (pend_o),
  .sync_fall    (sync_fall),
  .type_q       (type_q)
);

// File: tb/extint_cond_bench.sv
`timescale 1ns/1ps
module extint_cond_bench;
  localparam int N = 2;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_n = '1;
  logic [N-1:0] ack = '0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [N-1:0] pend;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  extint_cond u_extint_cond (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pin_ni       (pin_n),
    .vec_ack_i    (ack),
    .ctrl_we_i    (we),
    .ctrl_wdata_i (wdata),
    .ctrl_rdata_o (rdata),
    .pend_o       (pend)
  );

  // behavioural reference built from the requirements
  logic [N-1:0] m_s1, m_s2, m_prev, m_mode, m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_mode <= '0; m_flag <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic f;
        f = m_flag[i];
        if (!m_mode[i]) f = 1'b0;
        else begin
          if (ack[i]) f = 1'b0;
          if (we) f = wdata[2*i+1];
          if (m_prev[i] && !m_s2[i]) f = 1'b1;
        end
        m_flag[i] <= f;
        if (we) m_mode[i] <= wdata[2*i];
      end
      m_s1 <= pin_n; m_s2 <= m_s1; m_prev <= m_s2;
    end
  end

  function automatic logic [N-1:0] m_pend();
    for (int i = 0; i < N; i++) m_pend[i] = m_mode[i] ? m_flag[i] : ~m_s2[i];
  endfunction

  function automatic logic [W-1:0] m_byte();
    m_byte = '0;
    for (int i = 0; i < N; i++) begin
      m_byte[2*i]   = m_mode[i];
      m_byte[2*i+1] = m_pend()[i];
    end
  endfunction

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [W-1:0] d);
    we = 1'b1; wdata = d; step(); we = 1'b0; wdata = '0;
  endtask

  task automatic pulse_ack(input int k);
    ack[k] = 1'b1; step(); ack[k] = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    chk("R1", rdata, 8'h00);
    chk("R1", {6'b0, pend}, 8'h00);

    // level mode on pin 0
    pin_n[0] = 1'b0; step();
    chk("R2 early", {7'b0, pend[0]}, 8'h00);
    step();
    chk("R2", {7'b0, pend[0]}, 8'h01);
    chk("R10 level pend bit", rdata, 8'h02);
    pulse_ack(0);
    chk("R11", {7'b0, pend[0]}, 8'h01);
    pin_n[0] = 1'b1; step(2);
    chk("R3", {7'b0, pend[0]}, 8'h00);
    we = 1'b1; wdata = 8'h0A; step(); we = 1'b0; wdata = '0;
    chk("R9", rdata, 8'h00);
    step();
    chk("R9 later", {6'b0, pend}, 8'h00);

    // edge mode on pin 0
    wr(8'h01);
    chk("R10 mode bit", rdata, 8'h01);
    pin_n[0] = 1'b0; step(2);
    chk("R4 not early", {7'b0, pend[0]}, 8'h00);
    step();
    chk("R4", {7'b0, pend[0]}, 8'h01);
    pin_n[0] = 1'b1; step(3);
    chk("R5 pin released", {7'b0, pend[0]}, 8'h01);
    pulse_ack(0);
    chk("R6", {7'b0, pend[0]}, 8'h00);
    pin_n[0] = 1'b0; step(3);
    pulse_ack(0);
    step(3);
    chk("R5 held low", {7'b0, pend[0]}, 8'h00);
    pin_n[0] = 1'b1; step(3);

    // coincident edge and acknowledge
    pin_n[0] = 1'b0; step(2);
    pulse_ack(0);
    chk("R7", {7'b0, pend[0]}, 8'h01);
    pulse_ack(0);
    chk("R6 second", {7'b0, pend[0]}, 8'h00);
    pin_n[0] = 1'b1; step(3);

    // software write in edge mode
    wr(8'h03);
    chk("R8 set", rdata, 8'h03);
    ack[0] = 1'b1; wr(8'h03); ack[0] = 1'b0;
    chk("R8 write over ack", rdata, 8'h03);
    wr(8'h01);
    chk("R8 clear", rdata, 8'h01);

    // pin 1 independent of pin 0
    wr(8'h05);
    pin_n[1] = 1'b0; step(3);
    chk("R12", {6'b0, pend}, 8'h02);
    chk("R10 pin1 layout", rdata, 8'h0D);
    pulse_ack(1);
    chk("R12 ack1", rdata, 8'h05);
    pin_n[1] = 1'b1; step(3);

    // near-exhaustive random sweep against the reference
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(2) == 0) pin_n[i] = ~pin_n[i];
        ack[i] = ($urandom_range(3) == 0);
      end
      we = ($urandom_range(7) == 0);
      wdata = we ? W'($urandom_range(255)) : '0;
      step();
      chk("R12 sweep pend", {6'b0, pend}, {6'b0, m_pend()});
      chk("R10 sweep byte", rdata, m_byte());
    end
    we = 1'b0; ack = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule